// File: doc/BRIEF.md
# Board control and status registers

This block is a byte-wide register bank sitting on a simple local device bus. The bus has a chip select, a 3-bit offset, separate read and write strobes and 8-bit data. Software reads board-level status through it: the abort pushbutton, the two bus-speed strap pins, a set of presence-detect lines, an 8-position configuration switch and a geographical-address switch. Software also uses it to drive four board controls: an abort interrupt request, a board-fail LED, a self-clearing hard-reset request and a processor time-base enable.

Every external status input passes through a two-flop synchronizer before software can see it. The abort interrupt can be raised in two ways: by software, or by a press of the pushbutton. Once raised, it stays pending until software clears it. A mask bit can keep the interrupt request low. The hard-reset request stays high until the external reset generator returns a one-cycle done pulse.

The bus is plain control and status wiring with no back-pressure. A write takes effect at the clock edge where chip select and the write strobe are high together. A read is captured at the clock edge where chip select and the read strobe are high together. Its data appears on the read-data port in the next cycle and stays there until the next read. Reads and writes never stall.

Top module: `board_ctl_regs`

## Requirements
- R1: Offsets 2 and 3 read as 0x00. Writes to offsets 2, 3, 4, 5 and 7 change no output and no readable bit.
- R2: At offset 0, writing bit 7 = 0 makes the abort interrupt pending. Writing bit 7 = 1 clears it, unless a button press is detected in that same cycle.
- R3: A read of offset 0 returns the synchronized pushbutton level in bit 7, where 1 means released and 0 means pressed. Bits 6..0 read as 0.
- R4: A high-to-low change of the synchronized pushbutton level makes the abort interrupt pending three clock edges after the pin changes. It stays pending until software writes a 1 to bit 7 of offset 0.
- R5: While the mask bit (offset 1, bit 2) is set, the abort interrupt output is low. The pending state is kept, and the output rises once the mask is cleared.
- R6: Offset 1, bit 0 drives the board-fail LED output, where 1 means lit. It can be read back.
- R7: Writing 1 to offset 1, bit 1 raises the hard-reset request, which reads back in bit 1. The request stays high until a done pulse arrives and falls at that edge. Writing 0 to the bit has no effect.
- R8: Offset 1, bits 4 and 5 return the synchronized levels of bus-speed straps 0 and 1. A value of 0 means 33 MHz and 1 means 66 MHz.
- R9: Offsets 4, 5 and 7 are read-only and return, zero-extended, the synchronized presence-detect lines, configuration switch and geographical-address switch.
- R10: Offset 6, bit 0 drives the time-base enable output. Clearing the bit drives the output low.
- R11: After reset, the LED is off, the mask is clear, no interrupt is pending, there is no reset request, time-base enable is high and the read data is 0x00.
- R12: Read data is updated one cycle after a read strobe and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_i | input | 1 | Chip select |
| addr_i | input | 3 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| abort_sw_n_i | input | 1 | Abort pushbutton, low while pressed |
| spd_strap_i | input | 2 | Bus-speed strap pins |
| present_i | input | PD_W | Presence-detect lines |
| cfg_sw_i | input | CFG_W | Configuration switch positions |
| geo_sw_i | input | GA_W | Geographical-address switch |
| rst_done_i | input | 1 | Done pulse from the reset generator |
| abort_irq_o | output | 1 | Abort interrupt request |
| fail_led_o | output | 1 | Board-fail LED drive |
| hard_rst_req_o | output | 1 | Hard-reset request |
| tb_en_o | output | 1 | Processor time-base enable |

## Verification
Register-driven outputs change at the clock edge of the write, and read data appears one edge after the read strobe. A pin change first shows up in a read two edges after it is sampled. A button press raises the interrupt on the third edge. The reset request falls on the edge that samples the done pulse. The bench drives its inputs just after each rising edge. A behavioural model advances at that same edge with those same delays, and every output is compared with the model at the following falling edge. A result therefore counts only if it arrives in exactly the cycle it is due.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_ABORT = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PRES  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_TBEN  = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_GEO   = 3'd7;

  localparam int ABT_BIT  = 7;
  localparam int LED_BIT  = 0;
  localparam int RST_BIT  = 1;
  localparam int MASK_BIT = 2;
  localparam int SPD0_BIT = 4;
  localparam int SPD1_BIT = 5;
  localparam int TBEN_BIT = 0;

  typedef struct packed {
    logic led;
    logic mask;
    logic tben;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{led: 1'b0, mask: 1'b0, tben: 1'b1};
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bcr_abort.sv
module bcr_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_s,
  input  logic wr_raise,
  input  logic wr_clear,
  input  logic mask,
  output logic pend_o,
  output logic irq_o
);
  logic prev_q, pend_q, press;

  assign press = prev_q & ~btn_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= btn_n_s;
      if (press || wr_raise) pend_q <= 1'b1;
      else if (wr_clear)     pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ~mask;

  assert_press_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> pend_q);
  assert_wr_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_raise |=> pend_q);
  assert_wr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && !press) |=> !pend_q);
endmodule

// File: rtl/bcr_rstreq.sv
module bcr_rstreq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic done_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (set_i)  req_q <= 1'b1;
    else if (done_i) req_q <= 1'b0;
  end

  assign req_o = req_q;

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !done_i) |=> req_q);
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !set_i) |=> !req_q);
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import bcr_pkg::*;
#(
  parameter int PD_W = 8,
  parameter int CFG_W = 8,
  parameter int GA_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              abort_sw_n_i,
  input  logic [1:0]        spd_strap_i,
  input  logic [PD_W-1:0]   present_i,
  input  logic [CFG_W-1:0]  cfg_sw_i,
  input  logic [GA_W-1:0]   geo_sw_i,
  input  logic              rst_done_i,
  output logic              abort_irq_o,
  output logic              fail_led_o,
  output logic              hard_rst_req_o,
  output logic              tb_en_o
);
  localparam int SYN_W = 1 + 2 + PD_W + CFG_W + GA_W;
  localparam logic [SYN_W-1:0] SYN_RST = {1'b1, {(SYN_W-1){1'b0}}};

  logic [SYN_W-1:0] syn_in, syn_out;
  logic             btn_n_s;
  logic [1:0]       spd_s;
  logic [PD_W-1:0]  pd_s;
  logic [CFG_W-1:0] cfg_s;
  logic [GA_W-1:0]  ga_s;

  assign syn_in = {abort_sw_n_i, spd_strap_i, present_i, cfg_sw_i, geo_sw_i};
  assign {btn_n_s, spd_s, pd_s, cfg_s, ga_s} = syn_out;

  bcr_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(syn_in), .q_o(syn_out));

  logic rd_hit, wr_hit, wr_abort, wr_ctrl, wr_tben;
  assign rd_hit   = cs_i & rd_i;
  assign wr_hit   = cs_i & wr_i;
  assign wr_abort = wr_hit && (addr_i == OFS_ABORT);
  assign wr_ctrl  = wr_hit && (addr_i == OFS_CTRL);
  assign wr_tben  = wr_hit && (addr_i == OFS_TBEN);

  ctl_t ctl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else begin
      if (wr_ctrl) begin
        ctl_q.led  <= wdata_i[LED_BIT];
        ctl_q.mask <= wdata_i[MASK_BIT];
      end
      if (wr_tben) ctl_q.tben <= wdata_i[TBEN_BIT];
    end
  end

  logic pend, req;

  bcr_abort u_abort (
    .clk(clk), .rst_n(rst_n), .btn_n_s(btn_n_s),
    .wr_raise(wr_abort & ~wdata_i[ABT_BIT]),
    .wr_clear(wr_abort &  wdata_i[ABT_BIT]),
    .mask(ctl_q.mask), .pend_o(pend), .irq_o(abort_irq_o));

  bcr_rstreq u_rstreq (
    .clk(clk), .rst_n(rst_n), .set_i(wr_ctrl & wdata_i[RST_BIT]),
    .done_i(rst_done_i), .req_o(req));

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFS_ABORT: rd_mux[ABT_BIT] = btn_n_s;
      OFS_CTRL: begin
        rd_mux[LED_BIT]  = ctl_q.led;
        rd_mux[RST_BIT]  = req;
        rd_mux[MASK_BIT] = ctl_q.mask;
        rd_mux[SPD0_BIT] = spd_s[0];
        rd_mux[SPD1_BIT] = spd_s[1];
      end
      OFS_PRES: rd_mux[PD_W-1:0]  = pd_s;
      OFS_CFG:  rd_mux[CFG_W-1:0] = cfg_s;
      OFS_TBEN: rd_mux[TBEN_BIT]  = ctl_q.tben;
      OFS_GEO:  rd_mux[GA_W-1:0]  = ga_s;
      default:  rd_mux = '0;
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_mux;
  end

  assign rdata_o        = rdata_q;
  assign fail_led_o     = ctl_q.led;
  assign tb_en_o        = ctl_q.tben;
  assign hard_rst_req_o = req;

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(rdata_o));
  assert_tben_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tben |=> (tb_en_o == $past(wdata_i[TBEN_BIT])));
  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.mask |-> !abort_irq_o);
  assert_led_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (fail_led_o == $past(wdata_i[LED_BIT])));
endmodule

// File: tb/board_ctl_regs_tb.sv
`timescale 1ns/1ps
module board_ctl_regs_tb_top;
  localparam int PD_W = 8, CFG_W = 8, GA_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic btn_n = 1'b1;
  logic [1:0] spd = '0;
  logic [PD_W-1:0] pd = '0;
  logic [CFG_W-1:0] cfg = '0;
  logic [GA_W-1:0] geo = '0;
  logic done = 1'b0;
  logic irq, led, hreq, tben;

  always #2.5 clk = ~clk;

  board_ctl_regs #(.PD_W(PD_W), .CFG_W(CFG_W), .GA_W(GA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .abort_sw_n_i(btn_n), .spd_strap_i(spd),
    .present_i(pd), .cfg_sw_i(cfg), .geo_sw_i(geo), .rst_done_i(done),
    .abort_irq_o(irq), .fail_led_o(led), .hard_rst_req_o(hreq), .tb_en_o(tben));

  int n_tests = 0, n_fail = 0;

  // behavioural reference: pin delay lines and control state
  logic [7:0] m_rdata;
  string m_tag = "R12 R11";
  logic m_pend, m_mask, m_led, m_req, m_tben;
  logic btn_d[$], spd_d[$][1:0];
  logic [1:0] spd_h [3];
  logic [7:0] pd_h [3], cfg_h [3], geo_h [3];
  logic btn_h [3];

  function automatic logic [7:0] ref_read(input logic [2:0] a);
    logic [7:0] v = 8'h00;
    case (a)
      3'd0: v[7] = btn_h[1];
      3'd1: v = {2'b00, spd_h[1][1], spd_h[1][0], 1'b0, m_mask, m_req, m_led};
      3'd4: v = pd_h[1];
      3'd5: v = cfg_h[1];
      3'd6: v[0] = m_tben;
      3'd7: v = geo_h[1];
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd0: return "R12 R3";
      3'd1: return "R12 R8";
      3'd4, 3'd5, 3'd7: return "R12 R9";
      3'd6: return "R12 R10";
      default: return "R12 R1";
    endcase
  endfunction

  // index 0 = first stage, 1 = second stage (visible), 2 = previous visible
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdata = 8'h00; m_pend = 0; m_mask = 0; m_led = 0; m_req = 0; m_tben = 1;
      for (int i = 0; i < 3; i++) begin
        btn_h[i] = 1'b1; spd_h[i] = '0; pd_h[i] = '0; cfg_h[i] = '0; geo_h[i] = '0;
      end
    end else begin
      if (cs && rd) begin m_rdata = ref_read(addr); m_tag = tag_for(addr); end
      if (cs && wr && addr == 3'd0) m_pend = !wdata[7];
      if (btn_h[2] && !btn_h[1]) m_pend = 1'b1;
      if (cs && wr && addr == 3'd1) begin m_led = wdata[0]; m_mask = wdata[2]; end
      if (done) m_req = 1'b0;
      if (cs && wr && addr == 3'd1 && wdata[1]) m_req = 1'b1;
      if (cs && wr && addr == 3'd6) m_tben = wdata[0];
      btn_h[2] = btn_h[1]; btn_h[1] = btn_h[0]; btn_h[0] = btn_n;
      spd_h[1] = spd_h[0]; spd_h[0] = spd;
      pd_h[1] = pd_h[0];   pd_h[0] = pd;
      cfg_h[1] = cfg_h[0]; cfg_h[0] = cfg;
      geo_h[1] = geo_h[0]; geo_h[0] = {2'b00, geo};
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_tag, rdata, m_rdata);
      chk("R2 R4 R5 abort_irq", {7'b0, irq}, {7'b0, m_pend && !m_mask});
      chk("R6 fail_led", {7'b0, led}, {7'b0, m_led});
      chk("R7 hard_rst_req", {7'b0, hreq}, {7'b0, m_req});
      chk("R10 tb_en", {7'b0, tben}, {7'b0, m_tben});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a);
    @(posedge clk); #1;
    cs = 1; rd = 1; addr = a;
    @(posedge clk); #1;
    cs = 0; rd = 0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 explicit reset state
    chk("R11 led", {7'b0, led}, 8'h00);
    chk("R11 irq", {7'b0, irq}, 8'h00);
    chk("R11 req", {7'b0, hreq}, 8'h00);
    chk("R11 tben", {7'b0, tben}, 8'h01);
    chk("R11 rdata", rdata, 8'h00);

    // R1 R3 R8 R9 R10: read every offset with default pins
    for (int a = 0; a < 8; a++) bus_rd(a[2:0]);

    // R8 R9: new pin patterns
    spd = 2'b10; pd = 8'hA5; cfg = 8'h3C; geo = 6'h2B;
    idle(4);
    for (int a = 0; a < 8; a++) bus_rd(a[2:0]);
    spd = 2'b01; pd = 8'h5A; cfg = 8'hC3; geo = 6'h15;
    idle(4);
    bus_rd(3'd1); bus_rd(3'd4); bus_rd(3'd5); bus_rd(3'd7);

    // R1: writes to read-only and unused offsets are ignored
    bus_wr(3'd2, 8'hFF); bus_wr(3'd3, 8'hFF); bus_wr(3'd4, 8'h00);
    bus_wr(3'd5, 8'h00); bus_wr(3'd7, 8'h00);
    for (int a = 0; a < 8; a++) bus_rd(a[2:0]);

    // R2: software raise and clear
    bus_wr(3'd0, 8'h00); idle(2);
    bus_wr(3'd0, 8'h80); idle(2);

    // R3 R4: press, read pressed level, release, pending until cleared
    btn_n = 1'b0; idle(1); bus_rd(3'd0); idle(4); bus_rd(3'd0);
    btn_n = 1'b1; idle(6); bus_rd(3'd0);
    bus_wr(3'd0, 8'h7F); idle(2);
    bus_wr(3'd0, 8'h80); idle(2);

    // R5: mask hides a pending press, unmask releases it
    bus_wr(3'd1, 8'h04);
    btn_n = 1'b0; idle(6); btn_n = 1'b1; idle(4);
    bus_rd(3'd1);
    bus_wr(3'd1, 8'h00); idle(2);
    bus_wr(3'd0, 8'h80); idle(2);

    // R6: LED on and off
    bus_wr(3'd1, 8'h01); bus_rd(3'd1); bus_wr(3'd1, 8'h00); bus_rd(3'd1);

    // R7: reset request holds, write 0 ignored, done clears
    bus_wr(3'd1, 8'h02); idle(5); bus_rd(3'd1);
    bus_wr(3'd1, 8'h00); idle(3);
    @(posedge clk); #1 done = 1'b1;
    @(posedge clk); #1 done = 1'b0;
    idle(2); bus_rd(3'd1);

    // R10: time-base enable clear and set
    bus_wr(3'd6, 8'h00); bus_rd(3'd6); idle(2);
    bus_wr(3'd6, 8'hFF); bus_rd(3'd6);

    // R12: read data holds through idle cycles
    idle(8);

    idle(2);
    summary();
    $finish;
  end
endmodule